// File: doc/BRIEF.md
# Sprite Attribute Memory Port

This block sits between the processor's access path and a 544-byte sprite attribute store. Each request carries a wide byte address, a direction flag and, for writes, one data byte. The block reduces the address to the store's valid space: the low ten bits are kept, and any address in the upper half is folded onto a 32-byte table that repeats throughout that half. It then decides whether the raster is drawing visible lines. While drawing, the video logic owns the store, so every read and every write goes to one fixed byte instead of the requested one.

Requests arrive on a valid/ready stream. Writes complete in the cycle they are accepted. Reads return one byte on a valid/ready response stream one cycle after acceptance. A response that has not been taken holds its data and stalls new requests. Any response taken in the same cycle frees the slot at once. Each accepted write also produces a one-cycle pulse that marks the sprite list as stale for the evaluation logic, which lies outside this block.

The block exposes the physical store address, write enable and write data so that the store traffic can be observed. The display state comes from three plain control inputs: the vertical line counter, the overscan selection and the forced-blank flag.

Top module: `sam_port`

## Requirements
- R1: After reset, rsp_valid and stale_pulse are 0 and req_ready is 1.
- R2: Address bits above bit 9 of req_addr have no effect; only req_addr[9:0] selects a byte.
- R3: When bit 9 of the reduced address is 1, the store address is the reduced address ANDed with 0x21F, so the bytes 0x200 to 0x21F repeat across the upper half.
- R4: While force_blank is 1, every access uses the folded address of R2 and R3, whatever the line counter says.
- R5: While force_blank is 0, tall_mode is 0 and line_cnt is below 225, both reads and writes use byte 0x218. Line 225 and later use the folded address.
- R6: While force_blank is 0 and tall_mode is 1, the redirect of R5 applies below line 240 instead. Line 240 and later use the folded address.
- R7: A write that is accepted (req_valid, req_ready and req_write all 1) stores req_wdata at the chosen address at that clock edge. A later read of that address returns it.
- R8: stale_pulse is 1 for exactly the one cycle after each accepted write, whether redirected or not. Accepted reads do not raise it.
- R9: An accepted read sets rsp_valid in the next cycle, with rsp_data holding the byte stored at the chosen address. rsp_valid and rsp_data stay unchanged until rsp_ready is 1.
- R10: req_ready equals NOT rsp_valid OR rsp_ready. mem_we is 1 only in a cycle with an accepted write, and mem_addr then shows the chosen address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address before reduction |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte present |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | 8 | Read byte |
| line_cnt | input | 9 | Current vertical line |
| tall_mode | input | 1 | 1 = 240 visible lines, 0 = 225 |
| force_blank | input | 1 | 1 = display off, store free |
| mem_addr | output | 10 | Chosen store address |
| mem_we | output | 1 | Store write enable |
| mem_wdata | output | 8 | Store write byte |
| stale_pulse | output | 1 | Sprite list invalidated |

## Verification
On every cycle the assertions check the handshake: req_ready tracks the response slot, mem_we appears only with an accepted write, and a pending response holds still. They also check that each accepted write gives exactly one stale pulse, that a read produces a response, that the store address stays inside 544 bytes, and that the redirect to 0x218 happens during visible lines. Only the bench scenarios can show where the data actually lands. Those scenarios include the mirroring of the upper table, the discarding of high address bits, the line 224/225 and 239/240 edges, and a redirected write that is read back later through the folded address.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    ROUTE_FOLD     = 2'd0,
    ROUTE_REDIRECT = 2'd1
  } route_e;

  typedef struct packed {
    logic       wr;
    logic [7:0] data;
  } op_t;
endpackage

// File: rtl/sam_addr_fold.sv
module sam_addr_fold #(
  parameter int IN_W     = 16,
  parameter int MEM_AW   = 10,
  parameter int MIRROR_W = 5
) (
  input  logic [IN_W-1:0]   raw_addr,
  output logic [MEM_AW-1:0] fold_addr
);
  localparam int HI_BIT = MEM_AW - 1;
  localparam logic [MEM_AW-1:0] HI_KEEP =
    MEM_AW'((1 << HI_BIT) | ((1 << MIRROR_W) - 1));

  logic [MEM_AW-1:0] low_part;

  always_comb begin
    low_part = raw_addr[MEM_AW-1:0];
    if (low_part[HI_BIT]) fold_addr = low_part & HI_KEEP;
    else                  fold_addr = low_part;
  end
endmodule

// File: rtl/sam_region.sv
module sam_region #(
  parameter int VCNT_W    = 9,
  parameter int LINES_STD = 225,
  parameter int LINES_OVR = 240
) (
  input  logic              force_blank,
  input  logic              tall_mode,
  input  logic [VCNT_W-1:0] line_cnt,
  output sam_pkg::route_e   route
);
  localparam logic [VCNT_W-1:0] LIM_STD = VCNT_W'(LINES_STD);
  localparam logic [VCNT_W-1:0] LIM_OVR = VCNT_W'(LINES_OVR);

  logic [VCNT_W-1:0] limit;
  logic              drawing;

  always_comb begin
    limit   = tall_mode ? LIM_OVR : LIM_STD;
    drawing = !force_blank && (line_cnt < limit);
    route   = drawing ? sam_pkg::ROUTE_REDIRECT : sam_pkg::ROUTE_FOLD;
  end
endmodule

// File: rtl/sam_store.sv
module sam_store #(
  parameter int AW    = 10,
  parameter int DW    = 8,
  parameter int DEPTH = 544
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(addr) < DEPTH)) cells[addr] <= wdata;
    if (re) begin
      if (int'(addr) < DEPTH) rdata <= cells[addr];
      else                    rdata <= '0;
    end
  end
endmodule

// File: rtl/sam_port.sv
module sam_port #(
  parameter int ADDR_W    = 16,
  parameter int MEM_AW    = 10,
  parameter int DATA_W    = 8,
  parameter int VCNT_W    = 9,
  parameter int MIRROR_W  = 5,
  parameter int LINES_STD = 225,
  parameter int LINES_OVR = 240,
  parameter int PARK_ADDR = 'h218
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [VCNT_W-1:0] line_cnt,
  input  logic              tall_mode,
  input  logic              force_blank,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              stale_pulse
);
  import sam_pkg::*;

  localparam int DEPTH = (1 << (MEM_AW - 1)) + (1 << MIRROR_W);
  localparam logic [MEM_AW-1:0] PARK = MEM_AW'(PARK_ADDR);

  logic [MEM_AW-1:0] fold_addr;
  route_e            route;
  logic              take;
  logic              take_wr;
  logic              take_rd;

  sam_addr_fold #(
    .IN_W(ADDR_W), .MEM_AW(MEM_AW), .MIRROR_W(MIRROR_W)
  ) fold_i (
    .raw_addr(req_addr),
    .fold_addr(fold_addr)
  );

  sam_region #(
    .VCNT_W(VCNT_W), .LINES_STD(LINES_STD), .LINES_OVR(LINES_OVR)
  ) region_i (
    .force_blank(force_blank),
    .tall_mode(tall_mode),
    .line_cnt(line_cnt),
    .route(route)
  );

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    take      = req_valid && req_ready;
    take_wr   = take && req_write;
    take_rd   = take && !req_write;
    mem_addr  = (route == ROUTE_REDIRECT) ? PARK : fold_addr;
    mem_we    = take_wr;
    mem_wdata = req_wdata;
  end

  sam_store #(
    .AW(MEM_AW), .DW(DATA_W), .DEPTH(DEPTH)
  ) store_i (
    .clk(clk),
    .we(take_wr),
    .re(take_rd),
    .addr(mem_addr),
    .wdata(req_wdata),
    .rdata(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      stale_pulse <= 1'b0;
    end else begin
      stale_pulse <= take_wr;
      if (take_rd)        rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sam_port_chk.sv
module sam_port_chk #(
  parameter int MEM_AW    = 10,
  parameter int DATA_W    = 8,
  parameter int VCNT_W    = 9,
  parameter int LINES_STD = 225,
  parameter int LINES_OVR = 240,
  parameter int PARK_ADDR = 'h218,
  parameter int DEPTH     = 544
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [VCNT_W-1:0] line_cnt,
  input logic              tall_mode,
  input logic              force_blank,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_we,
  input logic              stale_pulse
);
  logic acc_wr;
  logic acc_rd;
  logic visible;

  always_comb begin
    acc_wr  = req_valid && req_ready && req_write;
    acc_rd  = req_valid && req_ready && !req_write;
    visible = !force_blank &&
              (int'(line_cnt) < (tall_mode ? LINES_OVR : LINES_STD));
  end

  AST_STALE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> stale_pulse); // R8
  AST_NO_STALE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> !stale_pulse); // R8
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_WE_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> acc_wr); // R10
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid) |-> req_ready); // R10
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(mem_addr) < DEPTH)); // R3
  AST_REDIRECT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && visible) |-> (int'(mem_addr) == PARK_ADDR)); // R5
endmodule

bind sam_port sam_port_chk #(
  .MEM_AW(MEM_AW), .DATA_W(DATA_W), .VCNT_W(VCNT_W),
  .LINES_STD(LINES_STD), .LINES_OVR(LINES_OVR),
  .PARK_ADDR(PARK_ADDR), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .line_cnt(line_cnt), .tall_mode(tall_mode),
  .force_blank(force_blank), .mem_addr(mem_addr), .mem_we(mem_we),
  .stale_pulse(stale_pulse)
);

// File: tb/sam_port_tb.sv
`timescale 1ns/1ps
module sam_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [8:0]  line_cnt = '0;
  logic        tall_mode = 1'b0;
  logic        force_blank = 1'b1;
  logic [9:0]  mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        stale_pulse;

  always #2 clk = ~clk;

  sam_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .line_cnt(line_cnt), .tall_mode(tall_mode), .force_blank(force_blank),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .stale_pulse(stale_pulse)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int m_mem [1024];
  bit m_rsp_valid = 0;
  int m_rsp_data = 0;
  bit m_stale = 0;

  function automatic int pick_addr(int raw, bit blank, bit tall, int line);
    int a;
    a = raw % 1024;
    if (a >= 512) a = 512 + (a % 32);
    if (!blank && line < (tall ? 240 : 225)) a = 'h218;
    return a;
  endfunction

  function automatic string addr_tag(int raw, bit blank, bit tall, int line);
    if (blank) return "R4";
    if (line < (tall ? 240 : 225)) return tall ? "R6" : "R5";
    if ((raw % 1024) >= 512) return "R3";
    if (raw >= 1024) return "R2";
    return "R7";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rsp_valid <= 0;
      m_stale <= 0;
    end else begin
      bit rdy;
      int a;
      rdy = !m_rsp_valid || rsp_ready;
      a = pick_addr(int'(req_addr), force_blank, tall_mode, int'(line_cnt));
      m_stale <= req_valid && rdy && req_write;
      if (req_valid && rdy && req_write) m_mem[a] = int'(req_wdata);
      if (req_valid && rdy && !req_write) begin
        m_rsp_valid <= 1;
        m_rsp_data <= m_mem[a];
      end else if (rsp_ready) m_rsp_valid <= 0;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit rdy;
      rdy = !m_rsp_valid || rsp_ready;
      check("R9 rsp_valid", int'(rsp_valid), int'(m_rsp_valid));
      if (m_rsp_valid) check("R9 rsp_data", int'(rsp_data), m_rsp_data);
      check("R8 stale_pulse", int'(stale_pulse), int'(m_stale));
      check("R10 req_ready", int'(req_ready), int'(rdy));
      check("R10 mem_we", int'(mem_we), int'(req_valid && rdy && req_write));
      if (req_valid && rdy)
        check(addr_tag(int'(req_addr), force_blank, tall_mode, int'(line_cnt)),
              int'(mem_addr),
              pick_addr(int'(req_addr), force_blank, tall_mode, int'(line_cnt)));
    end
  end

  task automatic drive(bit v, bit w, int a, int d);
    @(posedge clk); #1;
    req_valid = v; req_write = w; req_addr = 16'(a); req_wdata = 8'(d);
  endtask

  task automatic mode(bit blank, bit tall, int line);
    @(posedge clk); #1;
    req_valid = 0; force_blank = blank; tall_mode = tall; line_cnt = 9'(line);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 stale_pulse", int'(stale_pulse), 0);
    check("R1 req_ready", int'(req_ready), 1);
    @(negedge clk); rst_n = 1;
    // R7: fill the whole store with display off
    for (int i = 0; i < 544; i++) drive(1, 1, i, (i * 7 + 3) & 255);
    // R2/R3: reads with high bits and mirrored upper half
    for (int i = 0; i < 40; i++) drive(1, 0, 'hA400 + i * 13, 0);
    drive(1, 0, 'h3E5, 0);
    drive(1, 0, 'h7C01, 0);
    // R5: redirect during visible lines, boundary 224/225
    mode(0, 0, 100);
    drive(1, 1, 'h010, 'hC3);
    drive(1, 0, 'h055, 0);
    mode(0, 0, 224); drive(1, 0, 'h120, 0);
    mode(0, 0, 225); drive(1, 0, 'h120, 0);
    drive(1, 1, 'h120, 'h5A); drive(1, 0, 'h120, 0);
    // R6: tall mode boundary 239/240
    mode(0, 1, 230); drive(1, 1, 'h044, 'h99); drive(1, 0, 'h044, 0);
    mode(0, 1, 239); drive(1, 0, 'h300, 0);
    mode(0, 1, 240); drive(1, 0, 'h300, 0); drive(1, 0, 'h218, 0);
    // R4: blank overrides the line counter
    mode(1, 0, 10); drive(1, 0, 'h010, 0); drive(1, 1, 'h2F8, 'h11);
    // R9: back-pressure
    drive(1, 0, 'h0AA, 0);
    @(posedge clk); #1; rsp_ready = 0; req_addr = 16'h0BB;
    repeat (4) drive(1, 0, 'h0CC, 0);
    @(posedge clk); #1; rsp_ready = 1;
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      req_valid = ($urandom % 4) != 0;
      req_write = ($urandom % 2) != 0;
      req_addr = 16'($urandom);
      req_wdata = 8'($urandom);
      rsp_ready = ($urandom % 3) != 0;
      if ((i % 50) == 0) begin
        force_blank = ($urandom % 2) != 0;
        tall_mode = ($urandom % 2) != 0;
        line_cnt = 9'($urandom % 262);
      end
    end
    @(posedge clk); #1; req_valid = 0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule